// File: doc/BRIEF.md
# File Register Operate Unit

This block performs single-operand, byte-wide operations on an array of 128 eight-bit file registers and one eight-bit working register W. Four operations are supported: clearing a file register, clearing W, taking the bitwise inverse of a file register, and subtracting one from a file register. For the inverse and decrement operations, a destination bit chooses where the result goes: W, or back into the addressed file register. Every operation also updates a zero flag.

A controller presents an opcode, a 7-bit file address and the destination bit, then pulses the execute strobe for one clock. The result is registered on that clock edge. A separate combinational peek port reads any file register, so the array contents can be observed without changing them. No other flag is modelled, and there is no banking or indirect addressing.

Top module: `fro_unit`

## Requirements
- R1: After reset, W is 00h, Z is 0 and every file register holds 00h.
- R2: Opcode 0 (clear file) writes 00h to the addressed file register and sets Z to 1. W is left unchanged, whatever the destination bit.
- R3: Opcode 1 (clear W) writes 00h to W and sets Z to 1. All file registers are left unchanged.
- R4: Opcode 2 (complement) produces the bitwise inverse of the addressed register. Z is 1 exactly when that result is 00h.
- R5: Opcode 3 (decrement) produces the addressed register minus one, modulo 256. Decrementing 00h gives FFh with Z at 0, and a result of 00h gives Z at 1.
- R6: For opcodes 2 and 3, destination bit 0 writes the result to W and leaves the addressed register unchanged. Destination bit 1 writes the result to the addressed register and leaves W unchanged.
- R7: While the execute strobe is low, W, Z and every file register hold their values, whatever the opcode, address and destination inputs are.
- R8: An operation writes only the file register it addresses, and every address from 0 to 127 can be reached.
- R9: An operation whose strobe is sampled at a rising clock edge is visible on W, Z and the peek port immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe; high for one cycle per operation |
| op_i | input | 2 | Opcode: 0 clear file, 1 clear W, 2 complement, 3 decrement |
| addr_i | input | 7 | File register address of the operand |
| dest_i | input | 1 | Destination: 0 = W, 1 = file register |
| peek_addr_i | input | 7 | Address for the observation read port |
| peek_data_o | output | 8 | Current content of the register at peek_addr_i |
| w_o | output | 8 | Working register W |
| z_o | output | 1 | Zero flag |

## Verification
The bench targets three corner cases. The first is a decrement of 00h: a design that lets Z follow a borrow, or that saturates, would show 00h or set Z instead of giving FFh with Z clear. The second sends inverse and decrement results to W and then reads the source register back through the peek port: a design that writes both targets would corrupt that register. The third covers the clears. The bench issues a clear-file with destination 0 and checks that W survives and Z is forced high, and it issues strobe-low cycles with live opcodes and checks that nothing moves. A final sweep of all 128 addresses catches address decoding that is aliased or truncated.

// File: rtl/fro_pkg.sv
package fro_pkg;
    typedef enum logic [1:0] {
        OP_CLR_FILE = 2'd0,
        OP_CLR_W    = 2'd1,
        OP_INVERT   = 2'd2,
        OP_DECR     = 2'd3
    } fro_op_e;
endpackage

// File: rtl/fro_alu.sv
module fro_alu
    import fro_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  fro_op_e             op_i,
    input  logic                dest_i,
    input  logic [DATA_W-1:0]   operand_i,
    output logic [DATA_W-1:0]   result_o,
    output logic                zero_o,
    output logic                to_file_o,
    output logic                to_w_o
);
    always_comb begin
        result_o  = '0;
        to_file_o = 1'b0;
        to_w_o    = 1'b0;
        unique case (op_i)
            OP_CLR_FILE: begin
                result_o  = '0;
                to_file_o = 1'b1;
            end
            OP_CLR_W: begin
                result_o = '0;
                to_w_o   = 1'b1;
            end
            OP_INVERT: begin
                result_o  = ~operand_i;
                to_file_o = dest_i;
                to_w_o    = ~dest_i;
            end
            OP_DECR: begin
                result_o  = operand_i - DATA_W'(1);
                to_file_o = dest_i;
                to_w_o    = ~dest_i;
            end
            default: ;
        endcase
        zero_o = (result_o == '0);
    end
endmodule

// File: rtl/fro_regfile.sv
module fro_regfile #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] rd_addr_a_i,
    output logic [DATA_W-1:0] rd_data_a_o,
    input  logic [ADDR_W-1:0] rd_addr_b_i,
    output logic [DATA_W-1:0] rd_data_b_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we_i) begin
            mem_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_data_a_o = mem_q[rd_addr_a_i];
    assign rd_data_b_o = mem_q[rd_addr_b_i];
endmodule

// File: rtl/fro_unit.sv
module fro_unit
    import fro_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic [1:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              dest_i,
    input  logic [ADDR_W-1:0] peek_addr_i,
    output logic [DATA_W-1:0] peek_data_o,
    output logic [DATA_W-1:0] w_o,
    output logic              z_o
);
    typedef struct packed {
        logic [DATA_W-1:0] w;
        logic              z;
    } acc_t;

    acc_t              st_d, st_q;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] result;
    logic              res_zero;
    logic              to_file;
    logic              to_w;
    logic              file_we;

    fro_regfile #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (file_we),
        .waddr_i     (addr_i),
        .wdata_i     (result),
        .rd_addr_a_i (addr_i),
        .rd_data_a_o (operand),
        .rd_addr_b_i (peek_addr_i),
        .rd_data_b_o (peek_data_o)
    );

    fro_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op_i      (fro_op_e'(op_i)),
        .dest_i    (dest_i),
        .operand_i (operand),
        .result_o  (result),
        .zero_o    (res_zero),
        .to_file_o (to_file),
        .to_w_o    (to_w)
    );

    always_comb begin
        st_d    = st_q;
        file_we = exec_i & to_file;
        if (exec_i) begin
            st_d.z = res_zero;
            if (to_w) begin
                st_d.w = result;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign w_o = st_q.w;
    assign z_o = st_q.z;
endmodule

// File: rtl/fro_unit_chk.sv
module fro_unit_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exec_i,
    input logic [1:0]        op_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              dest_i,
    input logic [ADDR_W-1:0] peek_addr_i,
    input logic [DATA_W-1:0] peek_data_o,
    input logic [DATA_W-1:0] w_o,
    input logic              z_o
);
    // R7: no strobe, no change in W or Z
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> ($stable(w_o) && $stable(z_o)));

    // R3: clear W gives 00h and Z set
    a_r3_clear_w: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == 2'd1) |=> (w_o == '0 && z_o));

    // R2: clear file forces Z and keeps W
    a_r2_clear_file: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == 2'd0) |=> (z_o && $stable(w_o)));

    // R6: file destination keeps W
    a_r6_file_dest_keeps_w: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i[1] && dest_i) |=> $stable(w_o));

    // R4: result into W, Z reflects W
    a_r4_zero_tracks_w: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i[1] && !dest_i) |=> (z_o == (w_o == '0)));

    // R5: decrement into W, observed operand through peek
    a_r5_decrement_w: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == 2'd3 && !dest_i && peek_addr_i == addr_i)
        |=> (w_o == $past(peek_data_o) - DATA_W'(1)));

    // R6: W destination keeps the source register
    a_r6_w_dest_keeps_file: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i[1] && !dest_i && peek_addr_i == addr_i)
        |=> (peek_addr_i != $past(addr_i) || $stable(peek_data_o)));
endmodule

bind fro_unit fro_unit_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exec_i      (exec_i),
    .op_i        (op_i),
    .addr_i      (addr_i),
    .dest_i      (dest_i),
    .peek_addr_i (peek_addr_i),
    .peek_data_o (peek_data_o),
    .w_o         (w_o),
    .z_o         (z_o)
);

// File: tb/tb_fro_unit.sv
`timescale 1ns/1ps
module tb_fro_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_i = 1'b0;
    logic [1:0] op_i = '0;
    logic [6:0] addr_i = '0;
    logic       dest_i = 1'b0;
    logic [6:0] peek_addr_i = '0;
    logic [7:0] peek_data_o;
    logic [7:0] w_o;
    logic       z_o;

    int vectors = 0;
    int miscompares = 0;

    typedef struct {
        logic [7:0] w;
        logic       z;
        logic [7:0] data;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    logic [7:0] m_mem [128];
    logic [7:0] m_w = '0;
    logic       m_z = 1'b0;

    always #2.5 clk = ~clk;

    fro_unit dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .exec_i      (exec_i),
        .op_i        (op_i),
        .addr_i      (addr_i),
        .dest_i      (dest_i),
        .peek_addr_i (peek_addr_i),
        .peek_data_o (peek_data_o),
        .w_o         (w_o),
        .z_o         (z_o)
    );

    task automatic compare(string tag, logic [7:0] w, logic z, logic [7:0] d);
        vectors++;
        if (w_o !== w || z_o !== z || peek_data_o !== d) begin
            miscompares++;
            $display("FAIL %s: w=%h z=%b reg=%h, expected w=%h z=%b reg=%h",
                     tag, w_o, z_o, peek_data_o, w, z, d);
        end
    endtask

    task automatic do_op(logic [1:0] op, logic [6:0] a, logic d, string tag);
        exp_t e;
        logic [7:0] r;
        @(negedge clk);
        case (op)
            2'd0: begin r = 8'h00; m_mem[a] = r; end
            2'd1: begin r = 8'h00; m_w = r; end
            2'd2: begin r = ~m_mem[a]; if (d) m_mem[a] = r; else m_w = r; end
            default: begin r = m_mem[a] - 8'h01; if (d) m_mem[a] = r; else m_w = r; end
        endcase
        m_z = (r == 8'h00);
        e.w = m_w; e.z = m_z; e.data = m_mem[a]; e.tag = tag;
        sb_q.push_back(e);
        op_i = op; addr_i = a; dest_i = d; peek_addr_i = a; exec_i = 1'b1;
        @(negedge clk);
        exec_i = 1'b0;
    endtask

    // Monitor: result is visible right after the edge that samples the strobe (R9)
    initial begin
        forever begin
            @(posedge clk);
            if (exec_i === 1'b1) begin
                #1;
                if (sb_q.size() == 0) begin
                    vectors++; miscompares++;
                    $display("FAIL R9: result with no expected item");
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    compare(e.tag, e.w, e.z, e.data);
                end
            end
        end
    end

    task automatic idle_probe(logic [1:0] op, logic [6:0] a, logic d);
        @(negedge clk);
        op_i = op; addr_i = a; dest_i = d; peek_addr_i = a; exec_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        compare("R7 strobe low", m_w, m_z, m_mem[a]);
    endtask

    initial begin
        #500000;
        miscompares++;
        $display("FAIL watchdog: run did not complete, expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
        #12;
        rst_n = 1'b1;
        // R1: reset state
        for (int i = 0; i < 128; i += 37) begin
            @(negedge clk);
            peek_addr_i = 7'(i);
            #1;
            compare("R1 reset", 8'h00, 1'b0, 8'h00);
        end
        do_op(2'd2, 7'd5, 1'b0, "R4 R6 invert to W");
        do_op(2'd1, 7'd5, 1'b1, "R3 clear W");
        do_op(2'd2, 7'd5, 1'b1, "R4 R6 invert to file");
        do_op(2'd2, 7'd5, 1'b1, "R4 invert to zero");
        do_op(2'd3, 7'd5, 1'b1, "R5 decrement wrap");
        do_op(2'd3, 7'd5, 1'b0, "R5 R6 decrement to W");
        do_op(2'd0, 7'd5, 1'b0, "R2 clear file dest0");
        do_op(2'd2, 7'd4, 1'b1, "R4 setup");
        do_op(2'd3, 7'd4, 1'b1, "R5 setup");
        do_op(2'd2, 7'd4, 1'b1, "R4 to 01h");
        do_op(2'd3, 7'd4, 1'b1, "R5 decrement to zero");
        do_op(2'd3, 7'd0, 1'b0, "R5 decrement 00h to W");
        do_op(2'd2, 7'd127, 1'b1, "R8 top address");
        do_op(2'd3, 7'd127, 1'b0, "R8 R6 top to W");
        do_op(2'd2, 7'd64, 1'b1, "R8 mid address");
        do_op(2'd1, 7'd64, 1'b0, "R3 clear W again");
        do_op(2'd0, 7'd127, 1'b1, "R2 clear file dest1");
        idle_probe(2'd0, 7'd64, 1'b1);
        idle_probe(2'd1, 7'd4, 1'b0);
        idle_probe(2'd2, 7'd64, 1'b0);
        idle_probe(2'd3, 7'd5, 1'b1);
        for (int i = 0; i < 128; i += 9) begin
            do_op(2'd2, 7'(i), 1'b1, "R8 sweep invert");
            do_op(2'd3, 7'(i), 1'b1, "R8 sweep decrement");
        end
        // R8: scan all registers for stray writes
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            peek_addr_i = 7'(i);
            #1;
            compare("R8 scan", m_w, m_z, m_mem[i]);
        end
        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            vectors++; miscompares++;
            $display("FAIL R9: %0d results missing, expected 0", sb_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule